// File: doc/BRIEF.md
# Boot ROM Slave with Region-Decoded 64-bit Addressing

This block is a read-only memory slave on a Wishbone bus. It sits behind the bridge that turns processor bus cycles into Wishbone cycles, and it holds the first instruction words the core fetches after reset. Each entry is a 64-bit word, and the contents are fixed and computed inside the module.

Every request carries a 64-bit address with three parts. The top five bits are a one-hot code naming the target region. The next nineteen bits must be zero. The low forty bits are the physical address the core issued. The slave answers with an acknowledge only when the region code names the ROM and the zero band really is zero. Any other address gets an error response.

The word index is taken from the physical address just above its three byte-offset bits. Writes aimed at the ROM are acknowledged, but they do not change the ROM. Write data is therefore not brought into the block.

Top module: `boot_rom_wb`

## Requirements
- R1: A read (cyc_i=1, stb_i=1, we_i=0) with a valid address raises ack_o on the next clock edge. In that same cycle dat_o holds entry number adr_i[3+IDX_W-1:3], where IDX_W = log2(DEPTH) (bits [6:3] for the default 16 entries).
- R2: Entry k holds {8'hB0, k[7:0], (k*16'h1357)[15:0] ^ 16'hF00D, (k*32'h9E3779B1)[31:0]}, except entry 4, which holds 64'hC0F00B0103000000. So address 64'h800000FFF0000020 returns 64'hC0F00B0103000000.
- R3: Address bits [2:0] and physical-address bits [39:3+IDX_W] have no effect on the returned word.
- R4: ack_o stays high for exactly one clock. If strobe is still held high in the ack cycle, ack_o is low in the following cycle.
- R5: Neither ack_o nor err_o is raised while cyc_i is low, even when stb_i is high.
- R6: An address whose bits [63:59] differ from the ROM region code 5'b10000 gets err_o for one clock on the next edge, and ack_o stays low.
- R7: An address with any bit of [58:40] set gets err_o instead of ack_o.
- R8: A write (we_i=1) to a valid ROM address is acknowledged. A later read of the same entry still returns the R2 value.
- R9: While synchronous reset rst is high, ack_o, err_o and dat_o are cleared to zero on each clock edge.
- R10: ack_o and err_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Transfer strobe |
| we_i | input | 1 | Write enable; low for reads |
| adr_i | input | 64 | Region code, zero band and physical byte address |
| dat_o | output | 64 | Read data, valid with ack_o |
| ack_o | output | 1 | Transfer acknowledge |
| err_o | output | 1 | Error response for addresses outside the ROM |

## Verification
Two events can fall in the same cycle: the acknowledge of one transfer and a strobe that is still high and looks like a fresh request. The bench provokes this by holding cyc_i and stb_i high for three cycles on both a valid read and a bad address. It then judges the cycle after each response: the response must drop there, and dat_o must keep the word it just delivered. A related overlap is decode failure against acknowledge. Sweeps over all region codes and all zero-band bits check that err_o replaces ack_o and that the two never appear together.

// File: rtl/boot_rom_wb.sv
module boot_rom_wb #(
  parameter int          DEPTH       = 16,
  parameter logic [4:0]  REGION_CODE = 5'b10000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cyc_i,
  input  logic        stb_i,
  input  logic        we_i,
  input  logic [63:0] adr_i,
  output logic [63:0] dat_o,
  output logic        ack_o,
  output logic        err_o
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int IDX_HI = 3 + IDX_W;

  function automatic logic [63:0] rom_word(input logic [IDX_W-1:0] i);
    int k;
    k = int'(i);
    if (k == 4) return 64'hC0F00B0103000000;
    return {8'hB0, 8'(k), 16'(k * 16'h1357) ^ 16'hF00D, 32'(k) * 32'h9E3779B1};
  endfunction

  logic [IDX_W-1:0] idx;
  logic             hit, req;
  logic             unused_adr;

  assign idx        = adr_i[IDX_HI-1:3];
  assign hit        = (adr_i[63:59] == REGION_CODE) && (adr_i[58:40] == '0);
  assign req        = cyc_i & stb_i & ~ack_o & ~err_o;
  assign unused_adr = ^{adr_i[2:0], adr_i[39:IDX_HI]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o <= 1'b0;
      err_o <= 1'b0;
      dat_o <= '0;
    end else begin
      ack_o <= req & hit;
      err_o <= req & ~hit;
      if (req & hit & ~we_i) dat_o <= rom_word(idx);
    end
  end

  logic past_valid = 1'b0;
  always_ff @(posedge clk) past_valid <= 1'b1;

  // R4
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);

  // R5
  ack_needs_cyc_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o || err_o) |-> $past(cyc_i && stb_i));

  // R10
  ack_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ack_o && err_o));

  // R6
  err_single_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);

  // R6
  err_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(adr_i[63:59] != REGION_CODE || adr_i[58:40] != '0));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    (past_valid && $past(rst)) |-> (!ack_o && !err_o && dat_o == '0));
endmodule

// File: tb/tb_boot_rom_wb.sv
module tb_boot_rom_wb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_i = 1'b0, stb_i = 1'b0, we_i = 1'b0;
  logic [63:0] adr_i = '0;
  logic [63:0] dat_o;
  logic        ack_o, err_o;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  boot_rom_wb dut (.clk(clk), .rst(rst), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
                   .adr_i(adr_i), .dat_o(dat_o), .ack_o(ack_o), .err_o(err_o));

  function automatic logic [63:0] expect_word(input int k);
    if (k == 4) return 64'hC0F00B0103000000;
    return {8'hB0, 8'(k), 16'(k * 16'h1357) ^ 16'hF00D, 32'(k) * 32'h9E3779B1};
  endfunction

  function automatic logic [63:0] mk(input logic [4:0] rg, input logic [18:0] band, input logic [39:0] pa);
    return {rg, band, pa};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one transfer; samples at the negedge after the response edge
  task automatic xfer(input logic [63:0] a, input logic we, output logic ack, output logic err, output logic [63:0] d);
    @(negedge clk);
    cyc_i = 1; stb_i = 1; we_i = we; adr_i = a;
    @(negedge clk);
    ack = ack_o; err = err_o; d = dat_o;
    cyc_i = 0; stb_i = 0; we_i = 0;
    @(negedge clk);
    chk("R4 ack drops", {63'd0, ack_o}, 64'd0);
    chk("R10 err drops", {63'd0, err_o}, 64'd0);
  endtask

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a, e;
    logic [63:0] d;
    repeat (3) @(negedge clk);
    chk("R9 ack reset", {63'd0, ack_o}, 64'd0);
    chk("R9 err reset", {63'd0, err_o}, 64'd0);
    chk("R9 dat reset", dat_o, 64'd0);
    rst = 0;

    // R2 first fetch
    xfer(64'h800000FFF0000020, 0, a, e, d);
    chk("R2 fetch ack", {63'd0, a}, 64'd1);
    chk("R2 fetch data", d, 64'hC0F00B0103000000);

    // R1, R3 sweep all entries with varying offsets and high bits
    for (int k = 0; k < 16; k++) begin
      logic [39:0] pa;
      pa = {33'(k * 7 + 1), 4'(k), 3'(k)};
      xfer(mk(5'b10000, 19'd0, pa), 0, a, e, d);
      chk("R1 ack", {62'd0, e, a}, 64'd1);
      chk("R3 data", d, expect_word(k));
    end

    // R6 all region codes
    for (int r = 0; r < 32; r++) begin
      xfer(mk(5'(r), 19'd0, 40'h20), 0, a, e, d);
      if (r == 5'b10000) chk("R6 match", {62'd0, e, a}, 64'd1);
      else               chk("R6 miss err", {62'd0, e, a}, 64'd2);
    end

    // R7 each zero-band bit
    for (int b = 0; b < 19; b++) begin
      xfer(mk(5'b10000, 19'(1) << b, 40'h20), 0, a, e, d);
      chk("R7 band err", {62'd0, e, a}, 64'd2);
    end

    // R8 write then read back
    xfer(mk(5'b10000, 19'd0, 40'h18), 1, a, e, d);
    chk("R8 write ack", {62'd0, e, a}, 64'd1);
    xfer(mk(5'b10000, 19'd0, 40'h18), 0, a, e, d);
    chk("R8 unchanged", d, expect_word(3));

    // R5 strobe without cycle
    @(negedge clk);
    stb_i = 1; cyc_i = 0; adr_i = mk(5'b10000, 19'd0, 40'h8);
    repeat (3) begin
      @(negedge clk);
      chk("R5 no resp", {62'd0, err_o, ack_o}, 64'd0);
    end
    stb_i = 0;
    chk("R5 data held", dat_o, expect_word(3));

    // R4 held strobe: ack, gap, ack
    @(negedge clk);
    cyc_i = 1; stb_i = 1; adr_i = mk(5'b10000, 19'd0, 40'h30);
    @(negedge clk);
    chk("R4 first ack", {63'd0, ack_o}, 64'd1);
    chk("R4 data", dat_o, expect_word(6));
    @(negedge clk);
    chk("R4 gap", {62'd0, err_o, ack_o}, 64'd0);
    chk("R4 data stable", dat_o, expect_word(6));
    @(negedge clk);
    chk("R4 second ack", {63'd0, ack_o}, 64'd1);
    adr_i = mk(5'b01000, 19'd0, 40'h30);
    @(negedge clk);
    chk("R10 gap before err", {62'd0, err_o, ack_o}, 64'd0);
    @(negedge clk);
    chk("R10 err alone", {62'd0, err_o, ack_o}, 64'd2);
    chk("R10 data kept", dat_o, expect_word(6));
    @(negedge clk);
    chk("R10 err gap", {62'd0, err_o, ack_o}, 64'd0);
    cyc_i = 0; stb_i = 0;

    // R9 reset mid-run
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk("R9 dat cleared", dat_o, 64'd0);
    rst = 0;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule